// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block is a trace sink. It takes a stream of 32-bit trace words over a valid/ready handshake and writes them into an on-chip RAM that works as a ring. Once the write pointer passes the last entry, the newest words overwrite the oldest ones. A trigger input marks the event of interest. After the trigger the block keeps only a programmed number of further words, so the ring holds history from both sides of the event.

Software drives the block over a simple word-wide register bus. It starts capture, sets the post-trigger word count, and can ask for a manual flush that optionally halts capture. Once capture has halted, software drains the contents one word per read of the drain register, oldest word first. When the stored words are used up, the drain register returns an all-ones marker word, so a reader can loop until it sees that value.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset these values read back: status (0x00C) is 0x4, with bit 2 = ready, bit 1 = triggered and bit 0 = wrapped. Control (0x020) reads 0, depth (0x004) reads DEPTH, mode (0x028) reads 0 (circular), the write pointer (0x018) reads 0 and flush control (0x304) reads 0.
- R2: A write to control with bit 0 = 1 starts capture. It clears the write pointer, the read pointer (0x014) and status bits 0 to 2. `trace_ready` is high from the next cycle on, and control reads 1 while capture runs.
- R3: During capture, each accepted word (`trace_valid` and `trace_ready` high at a clock edge) is written at the write pointer, and the pointer then steps modulo DEPTH. Stepping from DEPTH-1 to 0 sets status bit 0. The bit stays set until the next start.
- R4: The first `trig_in` pulse during capture sets status bit 1. Every later pulse is ignored until the next start, and it does not reload the post-trigger count.
- R5: With N in the trigger count register (0x01C), capture halts once N more words have been accepted after the trigger cycle. A word accepted in the trigger cycle is stored but not counted. With N = 0, capture halts at the trigger edge itself.
- R6: A write to control with bit 0 = 0 halts capture. While capture is halted, `trace_ready` is low and offered words are dropped, leaving the write pointer unchanged.
- R7: A write to 0x304 with bit 6 set starts a flush. Bit 6 reads 1 for FLUSH_LAT cycles and then clears by itself. Bit 12 reads back the stored stop-on-flush choice. If stop-on-flush is 1, flush completion halts capture; if it is 0, capture continues.
- R8: After capture halts, each read of 0x010 returns the next stored word and advances the read pointer. Without a wrap, reading starts at entry 0 and returns write-pointer many words. After a wrap, reading starts at the write pointer and returns DEPTH words. After that, reads return 0xFFFFFFFF.
- R9: While capture runs, a read of 0x010 returns 0xFFFFFFFF and does not move the read pointer.
- R10: Status bit 2 (ready) is 0 while capture runs or a flush is in progress, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_valid | input | 1 | Trace word offered |
| trace_data | input | 32 | Trace word |
| trace_ready | output | 1 | Block accepts trace words (capture running) |
| trig_in | input | 1 | Trigger event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (the drain register advances on it) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the address |

## Verification
A short capture with no wrap shows that draining starts at entry 0 and ends with the marker. An overfilled capture shows that draining starts at the write pointer and yields exactly DEPTH words. Trigger runs with a nonzero count and with a zero count, plus a repeated trigger pulse, separate a counter that reloads from one that is sticky, and they also pin down whether the trigger-cycle word is counted. Flushes with and without stop-on-flush, and with halting by a control write, show that each halt path fixes the same drain window and that traffic offered while halted never lands in the ring.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int WORD_W = 32;

  localparam logic [11:0] OFS_DEPTH  = 12'h004;
  localparam logic [11:0] OFS_STAT   = 12'h00C;
  localparam logic [11:0] OFS_DRAIN  = 12'h010;
  localparam logic [11:0] OFS_RPTR   = 12'h014;
  localparam logic [11:0] OFS_WPTR   = 12'h018;
  localparam logic [11:0] OFS_TRGCNT = 12'h01C;
  localparam logic [11:0] OFS_CTRL   = 12'h020;
  localparam logic [11:0] OFS_MODE   = 12'h028;
  localparam logic [11:0] OFS_FLUSH  = 12'h304;

  localparam int CTRL_RUN_BIT   = 0;
  localparam int STAT_WRAP_BIT  = 0;
  localparam int STAT_TRIG_BIT  = 1;
  localparam int STAT_RDY_BIT   = 2;
  localparam int FLUSH_REQ_BIT  = 6;
  localparam int FLUSH_STOP_BIT = 12;

  localparam logic [WORD_W-1:0] EMPTY_WORD = '1;

  // next ring position
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // first entry to drain once capture halts
  function automatic int unsigned drain_base(logic wrapped, int unsigned wp);
    return wrapped ? wp : 0;
  endfunction

  // number of entries to drain once capture halts
  function automatic int unsigned drain_len(logic wrapped, int unsigned wp,
                                            int unsigned depth);
    return wrapped ? depth : wp;
  endfunction
endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trs_capture_ctrl.sv
module trs_capture_ctrl #(
  parameter int CNT_W     = 32,
  parameter int FLUSH_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_run,
  input  logic             flush_wr,
  input  logic             flush_req,
  input  logic             flush_stop_bit,
  input  logic             trig_in,
  input  logic             accept,
  input  logic [CNT_W-1:0] trig_count,
  output logic             running,
  output logic             trig_seen,
  output logic             flush_busy,
  output logic             flush_stop_en,
  output logic             start_evt,
  output logic             stop_evt
);
  localparam int FCW = $clog2(FLUSH_LAT + 1);

  logic [CNT_W-1:0] post_left;
  logic [FCW-1:0]   flush_cnt;
  logic trig_hit, trig_stop, post_stop, flush_reload, flush_done, flush_stop, halt_req;

  always_comb begin
    start_evt    = ctrl_wr & ctrl_run;
    trig_hit     = running & trig_in & ~trig_seen & ~start_evt;
    trig_stop    = trig_hit & (trig_count == '0);
    post_stop    = running & trig_seen & accept & (post_left == CNT_W'(1));
    flush_reload = flush_wr & flush_req;
    flush_done   = flush_busy & (flush_cnt == FCW'(1)) & ~flush_reload;
    flush_stop   = flush_done & flush_stop_en;
    halt_req     = (ctrl_wr & ~ctrl_run) | trig_stop | post_stop | flush_stop;
    stop_evt     = running & ~start_evt & halt_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      trig_seen <= 1'b0;
      post_left <= '0;
    end else begin
      if (start_evt)     running <= 1'b1;
      else if (stop_evt) running <= 1'b0;

      if (start_evt)     trig_seen <= 1'b0;
      else if (trig_hit) trig_seen <= 1'b1;

      if (trig_hit)
        post_left <= trig_count;
      else if (trig_seen && accept && post_left != '0)
        post_left <= post_left - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_busy    <= 1'b0;
      flush_cnt     <= '0;
      flush_stop_en <= 1'b0;
    end else begin
      if (flush_wr) flush_stop_en <= flush_stop_bit;
      if (flush_reload) begin
        flush_busy <= 1'b1;
        flush_cnt  <= FCW'(FLUSH_LAT);
      end else if (flush_busy) begin
        flush_cnt <= flush_cnt - FCW'(1);
        if (flush_done) flush_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trs_ring_ptrs.sv
module trs_ring_ptrs
  import trs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          accept,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          wrapped,
  output logic [AW:0]   avail
);
  localparam int CW = AW + 1;

  logic [AW-1:0] wptr_nxt;
  logic          wrap_nxt;

  always_comb begin
    wptr_nxt = accept ? AW'(ring_next(32'(wptr), DEPTH)) : wptr;
    wrap_nxt = wrapped | (accept & (wptr == AW'(DEPTH - 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      wrapped <= 1'b0;
      avail   <= '0;
    end else if (start_evt) begin
      wptr    <= '0;
      rptr    <= '0;
      wrapped <= 1'b0;
      avail   <= '0;
    end else begin
      wptr    <= wptr_nxt;
      wrapped <= wrap_nxt;
      if (stop_evt) begin
        // window fixed from the post-edge pointer so a final word is included
        rptr  <= AW'(drain_base(wrap_nxt, 32'(wptr_nxt)));
        avail <= CW'(drain_len(wrap_nxt, 32'(wptr_nxt), DEPTH));
      end else if (pop) begin
        rptr  <= AW'(ring_next(32'(rptr), DEPTH));
        avail <= avail - CW'(1);
      end
    end
  end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trs_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int FLUSH_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trace_valid,
  input  logic [31:0] trace_data,
  output logic        trace_ready,
  input  logic        trig_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int AW = $clog2(DEPTH);

  logic              running, trig_seen, flush_busy, flush_stop_en;
  logic              start_evt, stop_evt, accept, pop, ready_flag;
  logic              ctrl_wr, flush_wr, trgcnt_wr;
  logic [WORD_W-1:0] trig_count, ram_q;
  logic [AW-1:0]     wptr, rptr;
  logic              wrapped;
  logic [AW:0]       avail;

  assign ctrl_wr     = reg_wr && reg_addr == OFS_CTRL;
  assign flush_wr    = reg_wr && reg_addr == OFS_FLUSH;
  assign trgcnt_wr   = reg_wr && reg_addr == OFS_TRGCNT;
  assign trace_ready = running;
  assign accept      = trace_valid & trace_ready;
  assign ready_flag  = ~running & ~flush_busy;
  assign pop         = reg_rd && reg_addr == OFS_DRAIN && !running && avail != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         trig_count <= '0;
    else if (trgcnt_wr) trig_count <= reg_wdata;
  end

  trs_capture_ctrl #(.CNT_W(WORD_W), .FLUSH_LAT(FLUSH_LAT)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_wr        (ctrl_wr),
    .ctrl_run       (reg_wdata[CTRL_RUN_BIT]),
    .flush_wr       (flush_wr),
    .flush_req      (reg_wdata[FLUSH_REQ_BIT]),
    .flush_stop_bit (reg_wdata[FLUSH_STOP_BIT]),
    .trig_in        (trig_in),
    .accept         (accept),
    .trig_count     (trig_count),
    .running        (running),
    .trig_seen      (trig_seen),
    .flush_busy     (flush_busy),
    .flush_stop_en  (flush_stop_en),
    .start_evt      (start_evt),
    .stop_evt       (stop_evt)
  );

  trs_ring_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .accept    (accept),
    .pop       (pop),
    .wptr      (wptr),
    .rptr      (rptr),
    .wrapped   (wrapped),
    .avail     (avail)
  );

  trs_ram #(.DW(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (accept & ~start_evt),
    .waddr (wptr),
    .wdata (trace_data),
    .raddr (rptr),
    .rdata (ram_q)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_DEPTH:  reg_rdata = WORD_W'(DEPTH);
      OFS_STAT: begin
        reg_rdata[STAT_WRAP_BIT] = wrapped;
        reg_rdata[STAT_TRIG_BIT] = trig_seen;
        reg_rdata[STAT_RDY_BIT]  = ready_flag;
      end
      OFS_DRAIN:  reg_rdata = (!running && avail != '0) ? ram_q : EMPTY_WORD;
      OFS_RPTR:   reg_rdata = WORD_W'(rptr);
      OFS_WPTR:   reg_rdata = WORD_W'(wptr);
      OFS_TRGCNT: reg_rdata = trig_count;
      OFS_CTRL:   reg_rdata[CTRL_RUN_BIT] = running;
      OFS_MODE:   reg_rdata = '0;
      OFS_FLUSH: begin
        reg_rdata[FLUSH_REQ_BIT]  = flush_busy;
        reg_rdata[FLUSH_STOP_BIT] = flush_stop_en;
      end
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trace_ring_sink_chk.sv
module trace_ring_sink_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic          trace_ready,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          trig_seen,
  input logic [AW-1:0] wptr,
  input logic          wrapped,
  input logic [AW:0]   avail,
  input logic          flush_busy,
  input logic          flush_stop_en
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (wptr == '0 && !wrapped && !trig_seen && running));

  a_r4_trig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_seen && !start_evt) |=> trig_seen);

  a_r6_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !trace_ready);

  a_r9_no_drain_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> avail == '0);

  a_r7_flush_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flush_busy) && $past(flush_stop_en) && !$past(start_evt)) |-> !running);

  a_r8_avail_bound: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= (AW + 1)'(DEPTH));
endmodule

bind trace_ring_sink trace_ring_sink_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .running       (running),
  .trace_ready   (trace_ready),
  .start_evt     (start_evt),
  .stop_evt      (stop_evt),
  .trig_seen     (trig_seen),
  .wptr          (wptr),
  .wrapped       (wrapped),
  .avail         (avail),
  .flush_busy    (flush_busy),
  .flush_stop_en (flush_stop_en)
);

// File: tb/trace_ring_sink_bench.sv
module trace_ring_sink_bench;
  localparam int DEPTH = 8;
  localparam int FL    = 4;
  localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_DRAIN = 12'h010,
                          A_RPTR = 12'h014, A_WPTR = 12'h018, A_TRG = 12'h01C,
                          A_CTRL = 12'h020, A_MODE = 12'h028, A_FLUSH = 12'h304;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_valid = 1'b0;
  logic [31:0] trace_data = '0;
  logic        trace_ready;
  logic        trig_in = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] ring [DEPTH];
  int  m_wp = 0;
  bit  m_wrap = 0;

  always #4 clk = ~clk;

  trace_ring_sink #(.DEPTH(DEPTH), .FLUSH_LAT(FL)) u_trace_ring_sink (
    .clk(clk), .rst_n(rst_n), .trace_valid(trace_valid), .trace_data(trace_data),
    .trace_ready(trace_ready), .trig_in(trig_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(string req, string what, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic start_cap();
    wr(A_CTRL, 32'h1);
    m_wp = 0; m_wrap = 0;
  endtask

  // offer one word; the bench ring takes it only when the block is capturing
  task automatic push(logic [31:0] d, logic trig);
    if (trace_ready) begin
      ring[m_wp] = d;
      if (m_wp == DEPTH - 1) begin m_wp = 0; m_wrap = 1; end
      else m_wp = m_wp + 1;
    end
    trace_valid = 1'b1; trace_data = d; trig_in = trig;
    @(negedge clk);
    trace_valid = 1'b0; trig_in = 1'b0;
  endtask

  task automatic drain_chk(string req);
    int first = m_wrap ? m_wp : 0;
    int n     = m_wrap ? DEPTH : m_wp;
    for (int i = 0; i < n; i++)
      rd_chk(req, "drain word", A_DRAIN, ring[(first + i) % DEPTH]);
    rd_chk(req, "drain end marker", A_DRAIN, 32'hFFFF_FFFF);
    rd_chk(req, "read pointer after drain", A_RPTR, 32'((first + n) % DEPTH));
  endtask

  task automatic t_reset();
    rd_chk("R1", "status", A_STAT, 32'h4);
    rd_chk("R1", "control", A_CTRL, 32'h0);
    rd_chk("R1", "depth", A_DEPTH, DEPTH);
    rd_chk("R1", "mode", A_MODE, 32'h0);
    rd_chk("R1", "write pointer", A_WPTR, 32'h0);
    rd_chk("R1", "flush control", A_FLUSH, 32'h0);
    chk("R6", "trace_ready at reset", {31'b0, trace_ready}, 32'h0);
  endtask

  task automatic t_basic();
    start_cap();
    chk("R2", "trace_ready after start", {31'b0, trace_ready}, 32'h1);
    rd_chk("R2", "status after start", A_STAT, 32'h0);
    rd_chk("R2", "control while running", A_CTRL, 32'h1);
    for (int i = 0; i < 3; i++) push(32'hA000_0000 + 32'(i), 1'b0);
    rd_chk("R3", "write pointer", A_WPTR, 32'h3);
    rd_chk("R9", "drain while running", A_DRAIN, 32'hFFFF_FFFF);
    rd_chk("R9", "read pointer unmoved", A_RPTR, 32'h0);
    wr(A_CTRL, 32'h0);
    chk("R6", "trace_ready after halt", {31'b0, trace_ready}, 32'h0);
    rd_chk("R10", "status after halt", A_STAT, 32'h4);
    push(32'hDEAD_BEEF, 1'b0);
    rd_chk("R6", "write pointer after dropped word", A_WPTR, 32'h3);
    drain_chk("R8");
  endtask

  task automatic t_wrap();
    start_cap();
    for (int i = 0; i < DEPTH + 3; i++) push(32'h0000_0100 + 32'(i), 1'b0);
    rd_chk("R3", "status wrapped", A_STAT, 32'h1);
    rd_chk("R3", "write pointer after wrap", A_WPTR, 32'h3);
    wr(A_CTRL, 32'h0);
    rd_chk("R8", "status wrapped and ready", A_STAT, 32'h5);
    drain_chk("R8");
  endtask

  task automatic t_trigger();
    wr(A_TRG, 32'h2);
    start_cap();
    push(32'hB0, 1'b0);
    push(32'hB1, 1'b0);
    push(32'hB2, 1'b1);
    rd_chk("R4", "status triggered", A_STAT, 32'h2);
    push(32'hB3, 1'b1);
    chk("R4", "repeat trigger keeps capture", {31'b0, trace_ready}, 32'h1);
    push(32'hB4, 1'b0);
    chk("R5", "halt after count", {31'b0, trace_ready}, 32'h0);
    rd_chk("R5", "status triggered and ready", A_STAT, 32'h6);
    push(32'hB5, 1'b0);
    rd_chk("R5", "write pointer", A_WPTR, 32'h5);
    drain_chk("R5");
  endtask

  task automatic t_trig_zero();
    wr(A_TRG, 32'h0);
    start_cap();
    push(32'hC0, 1'b0);
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    chk("R5", "zero count halts at trigger", {31'b0, trace_ready}, 32'h0);
    rd_chk("R5", "status zero count", A_STAT, 32'h6);
    rd_chk("R5", "write pointer zero count", A_WPTR, 32'h1);
    drain_chk("R8");
  endtask

  task automatic t_flush_stop();
    start_cap();
    push(32'hD0, 1'b0);
    push(32'hD1, 1'b0);
    wr(A_FLUSH, 32'h0000_1040);
    rd_chk("R7", "flush busy", A_FLUSH, 32'h0000_1040);
    rd_chk("R10", "not ready during flush", A_STAT, 32'h0);
    repeat (FL) @(negedge clk);
    rd_chk("R7", "flush cleared", A_FLUSH, 32'h0000_1000);
    rd_chk("R10", "ready after flush stop", A_STAT, 32'h4);
    chk("R7", "capture halted by flush", {31'b0, trace_ready}, 32'h0);
    drain_chk("R8");
  endtask

  task automatic t_flush_keep();
    start_cap();
    wr(A_FLUSH, 32'h0000_0040);
    repeat (FL + 2) @(negedge clk);
    rd_chk("R7", "flush cleared no stop", A_FLUSH, 32'h0);
    rd_chk("R7", "capture continues", A_CTRL, 32'h1);
    push(32'hE0, 1'b0);
    rd_chk("R7", "word taken after flush", A_WPTR, 32'h1);
    wr(A_CTRL, 32'h0);
    drain_chk("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_trigger();
    t_trig_zero();
    t_flush_stop();
    t_flush_keep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule